// File: doc/BRIEF.md
# Ripple Adder-Subtractor with Sign Extension and Flags

This block adds or subtracts two N-bit two's-complement operands through a chain of one-bit full-adder cells. A single mode input chooses the operation. In subtract mode every bit of the second operand is inverted, and the mode bit enters as the carry into the lowest cell, so the chain forms A + ~B + 1.

The block reports four results. The first is the N-bit wrapped result. The second is a high word that widens the result to an exact 2N-bit signed value. The third is the unsigned carry from the top cell. The fourth is a signed-overflow flag, kept apart from the carry. The high word is filled with the true sign of the result, which is the result MSB corrected by the overflow flag. It is never filled from the carry. As a result, the {high, low} pair always holds the exact signed sum or difference.

The block is purely combinational and has no clock.

Top module: `addsub_ripple`

## Requirements
- R1: With sub_i = 0, lo_o equals (a_i + b_i) mod 2^N.
- R2: With sub_i = 1, lo_o equals (a_i - b_i) mod 2^N.
- R3: cout_o equals bit N of the unsigned sum a_i + (b_i XOR {N{sub_i}}) + sub_i. In subtract mode, 1 therefore means no borrow.
- R4: With sub_i = 0, ovf_o is 1 exactly when both operand MSBs are equal and the MSB of lo_o differs from them.
- R5: With sub_i = 1, ovf_o is 1 exactly when the operand MSBs differ and the MSB of lo_o differs from the MSB of a_i.
- R6: {hi_o, lo_o}, read as a 2N-bit signed number, equals the exact signed a_i + b_i or a_i - b_i. This holds even when ovf_o is 1.
- R7: Every bit of hi_o carries the same value: the MSB of lo_o XOR ovf_o, never cout_o. For example, 3 - 2 gives cout_o = 1 and hi_o = 0.
- R8: Adding 1 and all-ones gives lo_o = 0, ovf_o = 0 and cout_o = 1.
- R9: A one-bit cell with inputs a, b, carry-in c and mode m gives sum = a^b^m^c and carry = majority(a, b^m, c). This holds for all 16 input combinations.
- R10: All outputs follow an input change without any clock edge. N is a parameter of at least 2 and defaults to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, two's complement |
| b_i | input | N | Second operand, two's complement |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| lo_o | output | N | Wrapped N-bit result |
| hi_o | output | N | Sign-extension word of the exact result |
| cout_o | output | 1 | Carry leaving the top cell |
| ovf_o | output | 1 | Signed overflow |

## Verification
The assertions are immediate checks placed in combinational blocks. They assume every input is a settled two-state value whenever those blocks evaluate, because a ripple chain that was only half updated would trip them. The bench follows this rule: it changes all operand and mode inputs together and waits a delay before it looks at the outputs. It also never drives X or Z onto the operands. The operand patterns cover every value for both widths, so both signs and every carry path are reached.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;
  localparam int unsigned WIDTH_DEFAULT = 8;
  localparam int unsigned WIDTH_MIN     = 2;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/addsub_cell.sv
`timescale 1ns/1ps
module addsub_cell
  import addsub_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  input  logic sub_i,
  output logic sum_o,
  output logic cout_o
);
  logic b_eff;

  assign b_eff  = b_i ^ sub_i;
  assign sum_o  = a_i ^ b_eff ^ cin_i;
  assign cout_o = maj3(a_i, b_eff, cin_i);

  always_comb begin
    p_cell_r9: assert ({cout_o, sum_o} == 2'(a_i) + 2'(b_i ^ sub_i) + 2'(cin_i))
      else $error("cell mismatch");
  end
endmodule

// File: rtl/addsub_chain.sv
`timescale 1ns/1ps
module addsub_chain #(
  parameter int unsigned N = addsub_pkg::WIDTH_DEFAULT
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] sum_o,
  output logic [N:0]   carry_o
);
  assign carry_o[0] = sub_i;  // +1 of the two's-complement negate

  for (genvar i = 0; i < N; i++) begin : g_cell
    addsub_cell u_cell (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .cin_i (carry_o[i]),
      .sub_i (sub_i),
      .sum_o (sum_o[i]),
      .cout_o(carry_o[i+1])
    );
  end

  logic [N:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, a_i} + {1'b0, b_i ^ {N{sub_i}}} + {{N{1'b0}}, sub_i};
    p_cout_r3: assert (carry_o[N] == ref_sum[N]) else $error("carry mismatch");
    p_sum_r1: assert (sum_o == ref_sum[N-1:0]) else $error("sum mismatch");
  end
endmodule

// File: rtl/addsub_flags.sv
`timescale 1ns/1ps
module addsub_flags #(
  parameter int unsigned N = addsub_pkg::WIDTH_DEFAULT
) (
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic         sub_i,
  input  logic         sum_msb_i,
  input  logic         c_msb_i,
  input  logic         c_out_i,
  output logic         ovf_o,
  output logic [N-1:0] hi_o
);
  logic sign_true;

  assign ovf_o     = c_msb_i ^ c_out_i;  // carry into MSB vs carry out of MSB
  assign sign_true = sum_msb_i ^ ovf_o;
  assign hi_o      = {N{sign_true}};

  always_comb begin
    if (!sub_i) begin
      p_ovf_add_r4: assert (ovf_o == ((a_msb_i == b_msb_i) && (sum_msb_i != a_msb_i)))
        else $error("add overflow rule");
    end else begin
      p_ovf_sub_r5: assert (ovf_o == ((a_msb_i != b_msb_i) && (sum_msb_i != a_msb_i)))
        else $error("sub overflow rule");
    end
  end
endmodule

// File: rtl/addsub_ripple.sv
`timescale 1ns/1ps
module addsub_ripple #(
  parameter int unsigned N = addsub_pkg::WIDTH_DEFAULT
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         sub_i,
  output logic [N-1:0] lo_o,
  output logic [N-1:0] hi_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int unsigned WX = 2 * N;

  logic [N-1:0] sum;
  logic [N:0]   carry;

  addsub_chain #(.N(N)) u_chain (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .sum_o  (sum),
    .carry_o(carry)
  );

  addsub_flags #(.N(N)) u_flags (
    .a_msb_i  (a_i[N-1]),
    .b_msb_i  (b_i[N-1]),
    .sub_i    (sub_i),
    .sum_msb_i(sum[N-1]),
    .c_msb_i  (carry[N-1]),
    .c_out_i  (carry[N]),
    .ovf_o    (ovf_o),
    .hi_o     (hi_o)
  );

  assign lo_o   = sum;
  assign cout_o = carry[N];

  logic [WX-1:0] ext_a, ext_b, exact;
  always_comb begin
    ext_a = {{N{a_i[N-1]}}, a_i};
    ext_b = {{N{b_i[N-1]}}, b_i};
    exact = sub_i ? ext_a - ext_b : ext_a + ext_b;
    p_exact_r6: assert ({hi_o, lo_o} == exact) else $error("exact result mismatch");
    p_fill_r7: assert (hi_o == '0 || hi_o == '1) else $error("high word not uniform");
  end
endmodule

// File: tb/sim_addsub_ripple.sv
`timescale 1ns/1ps
module sim_addsub_ripple;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // N=6 instance
  logic [5:0] a6, b6, lo6, hi6;
  logic sub6, cout6, ovf6;
  addsub_ripple #(.N(6)) u0 (
    .a_i(a6), .b_i(b6), .sub_i(sub6),
    .lo_o(lo6), .hi_o(hi6), .cout_o(cout6), .ovf_o(ovf6)
  );

  // N=4 instance
  logic [3:0] a4, b4, lo4, hi4;
  logic sub4, cout4, ovf4;
  addsub_ripple #(.N(4)) u1 (
    .a_i(a4), .b_i(b4), .sub_i(sub4),
    .lo_o(lo4), .hi_o(hi4), .cout_o(cout4), .ovf_o(ovf4)
  );

  // single cell
  logic ca, cb, cc, cm, cs, cco;
  addsub_cell u_cell (
    .a_i(ca), .b_i(cb), .cin_i(cc), .sub_i(cm), .sum_o(cs), .cout_o(cco)
  );

  // {a[18:15], b[14:11], sub[10], lo[9:6], hi[5:2], cout[1], ovf[0]}
  localparam logic [18:0] VEC [10] = '{
    {4'd7,    4'd1,    1'b0, 4'b1000, 4'b0000, 1'b0, 1'b1},
    {4'b1000, 4'b1111, 1'b0, 4'b0111, 4'b1111, 1'b1, 1'b1},
    {4'd3,    4'd2,    1'b1, 4'b0001, 4'b0000, 1'b1, 1'b0},
    {4'd1,    4'b1111, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0},
    {4'b1000, 4'd1,    1'b1, 4'b0111, 4'b1111, 1'b1, 1'b1},
    {4'd7,    4'b1000, 1'b1, 4'b1111, 4'b0000, 1'b0, 1'b1},
    {4'd0,    4'd0,    1'b1, 4'b0000, 4'b0000, 1'b1, 1'b0},
    {4'd5,    4'd6,    1'b0, 4'b1011, 4'b0000, 1'b0, 1'b1},
    {4'b1101, 4'b1101, 1'b0, 4'b1010, 4'b1111, 1'b1, 1'b0},
    {4'd2,    4'd5,    1'b1, 4'b1101, 4'b1111, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    a6 = '0; b6 = '0; sub6 = 1'b0;
    a4 = '0; b4 = '0; sub4 = 1'b0;
    ca = 0; cb = 0; cc = 0; cm = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // quiescent state with zero operands (R1)
    chk("R1 zero lo", int'(lo4), 0);
    chk("R7 zero hi", int'(hi4), 0);
    chk("R3 zero cout", int'(cout4), 0);
    chk("R4 zero ovf", int'(ovf4), 0);

    // vector table (N=4)
    foreach (VEC[k]) begin
      @(negedge clk);
      a4 = VEC[k][18:15]; b4 = VEC[k][14:11]; sub4 = VEC[k][10];
      #1;
      chk(VEC[k][10] ? "R2 vec lo" : "R1 vec lo", int'(lo4), int'(VEC[k][9:6]));
      chk("R6 R7 vec hi", int'(hi4), int'(VEC[k][5:2]));
      chk("R3 vec cout", int'(cout4), int'(VEC[k][1]));
      chk(VEC[k][10] ? "R5 vec ovf" : "R4 vec ovf", int'(ovf4), int'(VEC[k][0]));
    end

    // exhaustive N=4
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          int sa, sb, ex, u;
          a4 = 4'(i); b4 = 4'(j); sub4 = m[0];
          #1;
          sa = int'($signed(a4)); sb = int'($signed(b4));
          ex = m[0] ? sa - sb : sa + sb;
          u  = i + int'(b4 ^ {4{m[0]}}) + m;
          chk(m[0] ? "R2 sweep4 lo" : "R1 sweep4 lo", int'(lo4), ex & 15);
          chk("R6 sweep4 exact", int'($signed({hi4, lo4})), ex);
          chk("R3 sweep4 cout", int'(cout4), (u >> 4) & 1);
          chk(m[0] ? "R5 sweep4 ovf" : "R4 sweep4 ovf", int'(ovf4), int'(ex > 7 || ex < -8));
        end

    // exhaustive N=6
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 64; j++) begin
          int sa, sb, ex, u;
          a6 = 6'(i); b6 = 6'(j); sub6 = m[0];
          #1;
          sa = int'($signed(a6)); sb = int'($signed(b6));
          ex = m[0] ? sa - sb : sa + sb;
          u  = i + int'(b6 ^ {6{m[0]}}) + m;
          chk(m[0] ? "R2 sweep6 lo" : "R1 sweep6 lo", int'(lo6), ex & 63);
          chk("R6 sweep6 exact", int'($signed({hi6, lo6})), ex);
          chk("R7 sweep6 fill", int'(hi6), ((lo6[5] ^ ovf6) ? 63 : 0));
          chk("R3 sweep6 cout", int'(cout6), (u >> 6) & 1);
          chk(m[0] ? "R5 sweep6 ovf" : "R4 sweep6 ovf", int'(ovf6), int'(ex > 31 || ex < -32));
        end

    // R8: 1 + (-1) at N=6
    a6 = 6'd1; b6 = 6'h3f; sub6 = 1'b0; #1;
    chk("R8 lo", int'(lo6), 0);
    chk("R8 ovf", int'(ovf6), 0);
    chk("R8 cout", int'(cout6), 1);

    // R7: 3 - 2 has carry but positive result
    a4 = 4'd3; b4 = 4'd2; sub4 = 1'b1; #1;
    chk("R7 carry set", int'(cout4), 1);
    chk("R7 hi from sign", int'(hi4), 0);

    // R9: cell, all 16 combinations
    for (int n = 0; n < 16; n++) begin
      int be;
      {ca, cb, cc, cm} = 4'(n);
      #1;
      be = int'(cb ^ cm);
      chk("R9 cell sum", int'(cs), int'(ca) ^ be ^ int'(cc));
      chk("R9 cell carry", int'(cco), int'((int'(ca) + be + int'(cc)) >= 2));
    end

    // R10: output follows input mid-cycle, no edge in between
    @(posedge clk); #2;
    a4 = 4'd4; b4 = 4'd3; sub4 = 1'b0; #1;
    chk("R10 comb lo", int'(lo4), 7);
    a4 = 4'd4; b4 = 4'd3; sub4 = 1'b1; #1;
    chk("R10 comb lo sub", int'(lo4), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule